// File: doc/BRIEF.md
# Banked CMOS Index/Data Port Decoder

This block sits behind the legacy pair of I/O ports that software uses to reach battery-backed CMOS RAM next to a real-time clock. The host first writes an index byte, then reads or writes the data port. The index port keeps only the low seven bits as the CMOS offset. Its top bit is kept as a separate NMI mask, so it never reaches the address.

The eighth CMOS address bit does not come from the index port. It comes from a chipset configuration byte, whose top bit opens the upper 128-byte bank. The same byte carries two power-control enables. It also has a status bit that always reads back as one, and four reserved bits that read back as zero.

A single-cycle access interface selects one of three targets (index, data, configuration). It returns read data one cycle later, together with a valid flag. The 256-byte CMOS RAM is modelled inside the block. The effective address and the read and write strobes toward it are brought out as ports.

Top module: `cmos_bank_port`

## Requirements
- R1: After reset the configuration byte reads 0x10, `nmiMask` is 1, `extBankEn`, `pwrCtrlEn` and `instOffEn` are 0, and `rdValid` is 0.
- R2: A write with `portSel` = 0 (index) stores `wrData[6:0]` as the CMOS index and drives `nmiMask` to `wrData[7]` from the next cycle on.
- R3: A read with `portSel` = 0 returns 0xFF.
- R4: The CMOS address presented on `cmosAddr` during a data access is {configuration bit 7, stored index[6:0]}. Bit 7 of the index write never reaches the address.
- R5: A write with `portSel` = 1 (data) stores `wrData` at the effective address. A read with `portSel` = 1 returns the byte stored there.
- R6: A read with `portSel` = 2 (configuration) returns bits 7:5 as last written, bit 4 as 1 whatever was written, and bits 3:0 as 0.
- R7: `extBankEn`, `pwrCtrlEn` and `instOffEn` follow configuration bits 7, 6 and 5 from the cycle after the write.
- R8: Every read has `rdValid` high, with `rdData`, exactly one cycle after `rdEn`. When `wrEn` and `rdEn` are both high, only the write takes place and `rdValid` stays low in the next cycle.
- R9: `portSel` = 3 selects nothing. A write there changes no state, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the selected target |
| rdEn | input | 1 | Read strobe for the selected target |
| portSel | input | 2 | Target: 0 index, 1 data, 2 configuration, 3 none |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid when rdValid is high |
| rdValid | output | 1 | High one cycle after an accepted read |
| nmiMask | output | 1 | 1 blocks NMIs (index write bit 7) |
| extBankEn | output | 1 | Upper CMOS bank enabled |
| pwrCtrlEn | output | 1 | Power-control enable |
| instOffEn | output | 1 | Instant power-off enable |
| cmosAddr | output | 8 | Effective CMOS address |
| cmosWr | output | 1 | Write strobe toward CMOS RAM |
| cmosRd | output | 1 | Read strobe toward CMOS RAM |

## Verification
A wrong bank bit shows up as the wrong byte on the first data read after the configuration byte changes. This is caught because the bench stores distinct patterns at the same low index in both banks. A corrupted index or NMI mask register shows on `cmosAddr` in the very cycle of the next data strobe, or on `nmiMask` one cycle after the index write. A mis-timed read path shows as `rdValid` arriving early, late or with no pending expectation, and the scoreboard reports it on that same cycle.

// File: rtl/cmos_bank_pkg.sv
package cmos_bank_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int INDEX_W = ADDR_W - 1;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] CFG_RESET = 8'h10;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_NONE  = 2'd3
  } portSelT;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic ramWr;
    logic ramRd;
    logic cfgWr;
    logic cfgRd;
    logic nulRd;
  } cmosStbT;
endpackage

// File: rtl/cmos_bank_ctrl.sv
module cmos_bank_ctrl
  import cmos_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic [1:0] portSel,
  output cmosStbT stb,
  output logic    rdValid
);
  portSelT selEnum;
  logic    rdTake;

  assign selEnum = portSelT'(portSel);
  // a write in the same cycle wins over a read
  assign rdTake  = rdEn && !wrEn;

  always_comb begin
    stb = '0;
    unique case (selEnum)
      SEL_INDEX: begin stb.idxWr = wrEn; stb.idxRd = rdTake; end
      SEL_DATA:  begin stb.ramWr = wrEn; stb.ramRd = rdTake; end
      SEL_CFG:   begin stb.cfgWr = wrEn; stb.cfgRd = rdTake; end
      default:   begin stb.nulRd = rdTake; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdTake;
  end
endmodule

// File: rtl/cmos_bank_dpath.sv
module cmos_bank_dpath
  import cmos_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmosStbT           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              nmiMask,
  output logic              extBankEn,
  output logic              pwrCtrlEn,
  output logic              instOffEn,
  output logic [ADDR_W-1:0] cmosAddr
);
  logic [INDEX_W-1:0] indexReg;
  logic [2:0]         cfgHi;
  logic [DATA_W-1:0]  cfgView;
  logic [DATA_W-1:0]  ramArr [DEPTH];

  // status bit 4 forced, reserved nibble zero
  assign cfgView   = {cfgHi, 1'b1, 4'b0000};
  assign cmosAddr  = {cfgHi[2], indexReg};
  assign extBankEn = cfgHi[2];
  assign pwrCtrlEn = cfgHi[1];
  assign instOffEn = cfgHi[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      nmiMask  <= 1'b1;
      cfgHi    <= CFG_RESET[7:5];
    end else begin
      if (stb.idxWr) begin
        indexReg <= wrData[INDEX_W-1:0];
        nmiMask  <= wrData[DATA_W-1];
      end
      if (stb.cfgWr) cfgHi <= wrData[7:5];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.ramWr) ramArr[cmosAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.idxRd) rdData <= '1;
    else if (stb.cfgRd) rdData <= cfgView;
    else if (stb.ramRd) rdData <= ramArr[cmosAddr];
    else if (stb.nulRd) rdData <= '0;
  end
endmodule

// File: rtl/cmos_bank_port.sv
module cmos_bank_port
  import cmos_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  portSel,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        nmiMask,
  output logic        extBankEn,
  output logic        pwrCtrlEn,
  output logic        instOffEn,
  output logic [7:0]  cmosAddr,
  output logic        cmosWr,
  output logic        cmosRd
);
  cmosStbT stb;

  cmos_bank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .portSel(portSel), .stb(stb), .rdValid(rdValid)
  );

  cmos_bank_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .nmiMask(nmiMask), .extBankEn(extBankEn),
    .pwrCtrlEn(pwrCtrlEn), .instOffEn(instOffEn), .cmosAddr(cmosAddr)
  );

  assign cmosWr = stb.ramWr;
  assign cmosRd = stb.ramRd;
endmodule

// File: rtl/cmos_bank_port_chk.sv
module cmos_bank_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [1:0] portSel,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       rdValid,
  input logic       nmiMask,
  input logic       extBankEn,
  input logic [7:0] cmosAddr,
  input logic       cmosWr,
  input logic       cmosRd
);
  // R2
  nmi_mask_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'd0) |=> (nmiMask == $past(wrData[7])));
  // R3
  index_read_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && portSel == 2'd0) |=> (rdValid && rdData == 8'hFF));
  // R6
  cfg_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && portSel == 2'd2) |=> (rdData[4] && rdData[3:0] == 4'h0));
  // R4
  bank_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmosWr || cmosRd) |-> (cmosAddr[7] == extBankEn));
  // R8
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid);
  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !rdValid);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmosWr && cmosRd));
endmodule

bind cmos_bank_port cmos_bank_port_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
  .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .nmiMask(nmiMask),
  .extBankEn(extBankEn), .cmosAddr(cmosAddr), .cmosWr(cmosWr), .cmosRd(cmosRd)
);

// File: tb/cmos_bank_port_bench.sv
module cmos_bank_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] portSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, cmosAddr;
  logic rdValid, nmiMask, extBankEn, pwrCtrlEn, instOffEn, cmosWr, cmosRd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  cmos_bank_port u_cmos_bank_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .nmiMask(nmiMask),
    .extBankEn(extBankEn), .pwrCtrlEn(pwrCtrlEn), .instOffEn(instOffEn),
    .cmosAddr(cmosAddr), .cmosWr(cmosWr), .cmosRd(cmosRd)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per rdValid
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual unexpected rdValid data %02h expected no read", rdData);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic doWrite(input logic [1:0] sel, input logic [7:0] d);
    portSel = sel; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    portSel = sel; rdEn = 1'b1; wrEn = 1'b0;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic drain;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 nmiMask", {7'd0, nmiMask}, 8'h01);
    check("R1 extBankEn", {5'd0, extBankEn, pwrCtrlEn, instOffEn}, 8'h00);
    check("R1 rdValid", {7'd0, rdValid}, 8'h00);
    doRead(2'd2, 8'h10, "R1 cfg reset");

    // R2 index and mask
    doWrite(2'd0, 8'h05);
    check("R2 mask clear", {7'd0, nmiMask}, 8'h00);
    doRead(2'd0, 8'hFF, "R3 index read");
    doWrite(2'd1, 8'hA5);
    // R7 bank enable
    doWrite(2'd2, 8'h80);
    check("R7 bank out", {5'd0, extBankEn, pwrCtrlEn, instOffEn}, 8'h04);
    doRead(2'd2, 8'h90, "R6 cfg 80");
    // R4 address with bank: sample during strobe
    portSel = 2'd1; wrData = 8'h3C; wrEn = 1'b1;
    #1;
    check("R4 addr bank1", cmosAddr, 8'h85);
    check("R4 wr strobe", {7'd0, cmosWr}, 8'h01);
    @(negedge clk); wrEn = 1'b0;
    doRead(2'd1, 8'h3C, "R5 bank1 read");
    doWrite(2'd2, 8'h00);
    doRead(2'd1, 8'hA5, "R4 bank0 read");
    // R2 index bit7 sets mask, not address
    doWrite(2'd0, 8'h85);
    check("R2 mask set", {7'd0, nmiMask}, 8'h01);
    doRead(2'd1, 8'hA5, "R4 index bit7 ignored");

    // R6/R7 config fields
    doWrite(2'd2, 8'hFF);
    check("R7 all enables", {5'd0, extBankEn, pwrCtrlEn, instOffEn}, 8'h07);
    doRead(2'd2, 8'hF0, "R6 cfg FF");
    doWrite(2'd2, 8'h4F);
    doRead(2'd2, 8'h50, "R6 cfg 4F");
    doWrite(2'd2, 8'h00);
    doRead(2'd2, 8'h10, "R6 cfg 00");

    // R5 pattern sweep across both banks
    for (int i = 0; i < 8; i++) begin
      doWrite(2'd2, (i % 2) ? 8'h80 : 8'h00);
      doWrite(2'd0, 8'(i * 16 + 3));
      doWrite(2'd1, 8'(8'h5A ^ (i * 37)));
    end
    for (int i = 0; i < 8; i++) begin
      doWrite(2'd2, (i % 2) ? 8'h80 : 8'h00);
      doWrite(2'd0, 8'(i * 16 + 3));
      doRead(2'd1, 8'(8'h5A ^ (i * 37)), "R5 sweep");
    end

    // R8 write wins over read
    doWrite(2'd2, 8'h00);
    doWrite(2'd0, 8'h7F);
    portSel = 2'd1; wrData = 8'hC3; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R8 no valid", {7'd0, rdValid}, 8'h00);
    doRead(2'd1, 8'hC3, "R8 write took effect");

    // R9 null select
    doWrite(2'd3, 8'hE7);
    doRead(2'd3, 8'h00, "R9 null read");
    doRead(2'd2, 8'h10, "R9 cfg unchanged");
    check("R9 mask unchanged", {7'd0, nmiMask}, 8'h00);
    doRead(2'd1, 8'hC3, "R9 index unchanged");

    drain();
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8: actual %0d pending reads expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule